// File: doc/BRIEF.md
# SD Block Data Transfer Controller

This block runs the data-line phase of a memory-card read or write. A host sets a block size, a block count, a bus width, a direction and a timeout in card clocks. It then sets the launch bit. From that point the controller steps through each block on its own. On a read it waits for a start bit, shifts data in from 1, 4 or 8 lanes, packs 32-bit words into an internal word FIFO and checks the CRC verdict. On a write it waits until the FIFO is full, then drives a start bit and shifts the words out. After the CRC window it waits for the card to release busy.

A one-cycle `sd_tick` marks each card clock. Bus-side registers are read combinationally and written through a simple strobe. A DMA engine fills and drains the FIFO through its push and pop ports. CRC16 generation and checking are done outside the block, which only samples their pass or fail result at the end of the CRC window. Any cause in the interrupt register raises `irq` until software clears it.

Top module: `sd_data_xfer`

## Requirements
- R1: After reset every register reads zero, `irq` and `dat_oe` are low, `dat_out` is all ones and the FIFO is empty.
- R2: Control register (address 0) fields are: block count [11:0], direction [12] (1 = write), launch [14], DMA enable [15], 4-bit bus [16], 8-bit bus [26]. The launch bit itself reads back as 0. Right after launch, the counter register (address 3) reads the block count in [11:0] and the block size in bytes in [23:12].
- R3: A launch is ignored if the block size (address 1, [11:0]) is zero or not a multiple of 4, or if the block count is zero. While a transfer is active, writes to addresses 0, 1 and 2 are ignored.
- R4: A read accepts a start bit when lane 0 is low on a tick. Lanes are then shifted in most-significant first, and every 32 bits are pushed to the FIFO as one word. During a block, counter bits [23:12] give the bits still to move divided by 8 (rounded down), and bits [11:0] give the blocks left, including the current one.
- R5: Bit 26 selects 8 lanes, and it wins over bit 16. Bit 16 alone selects 4 lanes. With neither bit set, one lane is used. On writes, the lanes that are not used are driven high.
- R6: A write drives nothing and stays in its waiting state until the FIFO is full. It then drives all lanes low for one tick as the start bit. After that it drives the FIFO words out most-significant first, with `dat_oe` high.
- R7: The timeout (address 2, 24 bits) is reloaded at launch and at each block boundary. The awaited event is a start bit on reads, or busy release on writes. If it has not arrived after timeout+1 consecutive waiting ticks, the transfer aborts, status bit 5 and interrupt bit 1 are set, and an event on that last tick is still accepted.
- R8: After data, a CRC window of 17 ticks follows. If `crc_fail` is high on its last tick, the transfer aborts. A read then sets status bit 6 and interrupt bit 2; a write sets status bit 7 and interrupt bit 3.
- R9: After each write block's CRC window, the block waits while lane 0 is low. The tick with lane 0 high ends busy and sets status bit 3 and interrupt bit 9.
- R10: Finishing the last block sets status bit 4 and interrupt bit 0 exactly once, and leaves the counter register at zero. Status bits 0 (read active) and 1 (write active) show the transfer in progress.
- R11: The interrupt register (address 6) is write-one-to-clear. A new cause wins over a clear in the same cycle, and `irq` is the OR of its bits.
- R12: The FIFO status register (address 5) shows full at bit 11 and the word count in its low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fifo_push | input | 1 | DMA pushes `fifo_wdata` |
| fifo_wdata | input | 32 | DMA write word |
| fifo_pop | input | 1 | DMA pops the head word |
| fifo_rdata | output | 32 | FIFO head word |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| sd_tick | input | 1 | One-cycle card clock strobe |
| dat_in | input | 8 | Sampled card data lanes |
| crc_fail | input | 1 | CRC verdict, sampled at the end of the CRC window |
| dat_out | output | 8 | Driven card data lanes |
| dat_oe | output | 1 | Lane drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the DMA side never pushes into a full FIFO and never pops from an empty one. They also take for granted that a read never brings in more words than the FIFO holds, and that a write block never runs dry mid-block. The stimulus keeps to this by sizing every transfer to at most the FIFO depth in words. On writes it fills the FIFO exactly before the first block; on reads it drains the FIFO only after the transfer ends. The sweep covers every width setting, several block sizes and counts, both timeout edges, and CRC failure in each direction.

// File: rtl/sd_data_xfer.sv
module sd_data_xfer #(
  parameter int FIFO_DEPTH = 8,
  parameter int CRC_TICKS  = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        fifo_push,
  input  logic [31:0] fifo_wdata,
  input  logic        fifo_pop,
  output logic [31:0] fifo_rdata,
  output logic        fifo_full,
  output logic        fifo_empty,
  input  logic        sd_tick,
  input  logic [7:0]  dat_in,
  input  logic        crc_fail,
  output logic [7:0]  dat_out,
  output logic        dat_oe,
  output logic        irq
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int PW = $clog2(CRC_TICKS);

  typedef enum logic [3:0] {
    S_IDLE, S_WFULL, S_RWAIT, S_RDATA, S_RCRC, S_TSTART, S_TDATA, S_TCRC, S_TBUSY
  } st_t;

  st_t         st;
  logic [11:0] bnum_q, bsize_q, blk_q;
  logic        dir_q, dma_q, wide_q, w8_q;
  logic [23:0] tcfg_q, tmo_q;
  logic [14:0] bits_q;
  logic [31:0] sreg;
  logic [PW-1:0] ph_q;
  logic [7:3]  sts_q;
  logic [9:0]  int_q;
  logic [7:0]  dout_q;
  logic        oe_q;

  logic [31:0] mem [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  logic [14:0] wstep, bits_nx;
  logic [31:0] rx_word, tx_shift, head;
  logic [7:0]  tx_lanes;
  logic        word_done, size_ok, go, idle, rx_on, tx_on;
  logic        push_bus, pop_bus, do_push, do_pop, wr_ok, rd_ok;
  logic        crc_end, ev_tmo, ev_rxcrc, ev_txcrc, ev_busy, blk_end, ev_done;
  logic [9:0]  int_set, int_clr;
  logic        unused_bits;

  assign unused_bits = ^{reg_wdata[31:27], reg_wdata[25:17], reg_wdata[13]};

  assign idle      = (st == S_IDLE);
  assign rx_on     = (st == S_RWAIT) || (st == S_RDATA) || (st == S_RCRC);
  assign tx_on     = !idle && !rx_on;
  assign wstep     = w8_q ? 15'd8 : (wide_q ? 15'd4 : 15'd1);
  assign bits_nx   = bits_q - wstep;
  assign word_done = (bits_nx[4:0] == 5'd0);
  assign size_ok   = (bsize_q[1:0] == 2'b00) && (bsize_q != 12'd0);
  assign go        = reg_we && (reg_addr == 3'd0) && reg_wdata[14] && idle
                     && size_ok && (reg_wdata[11:0] != 12'd0);

  always_comb begin
    if (w8_q) begin
      rx_word  = {sreg[23:0], dat_in};
      tx_shift = {sreg[23:0], 8'h00};
      tx_lanes = sreg[31:24];
    end else if (wide_q) begin
      rx_word  = {sreg[27:0], dat_in[3:0]};
      tx_shift = {sreg[27:0], 4'h0};
      tx_lanes = {4'hF, sreg[31:28]};
    end else begin
      rx_word  = {sreg[30:0], dat_in[0]};
      tx_shift = {sreg[30:0], 1'b0};
      tx_lanes = {7'h7F, sreg[31]};
    end
  end

  // FIFO
  assign fifo_full  = (cnt == (AW+1)'(FIFO_DEPTH));
  assign fifo_empty = (cnt == '0);
  assign head       = mem[rp];
  assign fifo_rdata = head;
  assign push_bus   = sd_tick && (st == S_RDATA) && word_done;
  assign pop_bus    = sd_tick && (((st == S_TSTART) && !fifo_empty) ||
                                  ((st == S_TDATA) && word_done && (bits_nx != 15'd0)));
  assign do_push    = push_bus || fifo_push;
  assign do_pop     = pop_bus || fifo_pop;
  assign wr_ok      = do_push && !fifo_full;
  assign rd_ok      = do_pop && !fifo_empty;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= push_bus ? rx_word : fifo_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    end

  // events
  assign crc_end  = sd_tick && ((st == S_RCRC) || (st == S_TCRC)) && (ph_q == PW'(CRC_TICKS-1));
  assign ev_tmo   = sd_tick && (tmo_q == 24'd0) &&
                    (((st == S_RWAIT) && dat_in[0]) || ((st == S_TBUSY) && !dat_in[0]));
  assign ev_rxcrc = crc_end && (st == S_RCRC) && crc_fail;
  assign ev_txcrc = crc_end && (st == S_TCRC) && crc_fail;
  assign ev_busy  = sd_tick && (st == S_TBUSY) && dat_in[0];
  assign blk_end  = (crc_end && (st == S_RCRC) && !crc_fail) || ev_busy;
  assign ev_done  = blk_end && (blk_q == 12'd1);
  assign int_set  = {ev_busy, 5'b0, ev_txcrc, ev_rxcrc, ev_tmo, ev_done};
  assign int_clr  = (reg_we && reg_addr == 3'd6) ? reg_wdata[9:0] : 10'd0;
  assign irq      = |int_q;
  assign dat_out  = dout_q;
  assign dat_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      int_q <= '0;
      sts_q <= '0;
    end else begin
      int_q <= (int_q & ~int_clr) | int_set;
      if (go) sts_q <= '0;
      else    sts_q <= sts_q | {ev_txcrc, ev_rxcrc, ev_tmo, ev_done, ev_busy};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      bnum_q <= '0; bsize_q <= '0; blk_q <= '0;
      dir_q <= 1'b0; dma_q <= 1'b0; wide_q <= 1'b0; w8_q <= 1'b0;
      tcfg_q <= '0; tmo_q <= '0; bits_q <= '0; sreg <= '0; ph_q <= '0;
      dout_q <= 8'hFF; oe_q <= 1'b0;
    end else begin
      if (reg_we && idle) begin
        case (reg_addr)
          3'd0: begin
            bnum_q <= reg_wdata[11:0]; dir_q <= reg_wdata[12]; dma_q <= reg_wdata[15];
            wide_q <= reg_wdata[16];   w8_q  <= reg_wdata[26];
          end
          3'd1: bsize_q <= reg_wdata[11:0];
          3'd2: tcfg_q  <= reg_wdata[23:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (go) begin
          blk_q  <= reg_wdata[11:0];
          bits_q <= {bsize_q, 3'b000};
          tmo_q  <= tcfg_q;
          st     <= reg_wdata[12] ? S_WFULL : S_RWAIT;
        end
        S_WFULL: if (fifo_full) st <= S_TSTART;
        S_RWAIT: if (sd_tick) begin
          if (!dat_in[0])            st <= S_RDATA;
          else if (tmo_q == 24'd0)   st <= S_IDLE;
          else                       tmo_q <= tmo_q - 24'd1;
        end
        S_RDATA: if (sd_tick) begin
          sreg   <= rx_word;
          bits_q <= bits_nx;
          if (bits_nx == 15'd0) begin st <= S_RCRC; ph_q <= '0; end
        end
        S_TSTART: if (sd_tick && !fifo_empty) begin
          sreg <= head; dout_q <= 8'h00; oe_q <= 1'b1; st <= S_TDATA;
        end
        S_TDATA: if (sd_tick) begin
          dout_q <= tx_lanes;
          sreg   <= (word_done && bits_nx != 15'd0) ? head : tx_shift;
          bits_q <= bits_nx;
          if (bits_nx == 15'd0) begin st <= S_TCRC; ph_q <= '0; end
        end
        S_RCRC, S_TCRC: if (sd_tick) begin
          oe_q <= 1'b0; dout_q <= 8'hFF;
          if (ph_q != PW'(CRC_TICKS-1)) ph_q <= ph_q + 1'b1;
          else if (crc_fail)            st <= S_IDLE;
          else if (st == S_TCRC) begin  st <= S_TBUSY; tmo_q <= tcfg_q; end
          else if (blk_q == 12'd1) begin blk_q <= '0; st <= S_IDLE; end
          else begin
            blk_q <= blk_q - 12'd1; bits_q <= {bsize_q, 3'b000};
            tmo_q <= tcfg_q; st <= S_RWAIT;
          end
        end
        S_TBUSY: if (sd_tick) begin
          if (dat_in[0]) begin
            if (blk_q == 12'd1) begin blk_q <= '0; st <= S_IDLE; end
            else begin
              blk_q <= blk_q - 12'd1; bits_q <= {bsize_q, 3'b000};
              tmo_q <= tcfg_q; st <= S_TSTART;
            end
          end
          else if (tmo_q == 24'd0) st <= S_IDLE;
          else                     tmo_q <= tmo_q - 24'd1;
        end
        default: st <= S_IDLE;
      endcase
    end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {5'b0, w8_q, 9'b0, wide_q, dma_q, 2'b0, dir_q, bnum_q};
      3'd1:    reg_rdata = {20'b0, bsize_q};
      3'd2:    reg_rdata = {8'b0, tcfg_q};
      3'd3:    reg_rdata = {8'b0, bits_q[14:3], blk_q};
      3'd4:    reg_rdata = {24'b0, sts_q, 1'b0, tx_on, rx_on};
      3'd5:    reg_rdata = {20'b0, fifo_full, 11'(cnt)};
      3'd6:    reg_rdata = {22'b0, int_q};
      default: reg_rdata = 32'b0;
    endcase
  end

  // R12
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> !fifo_full);
  // R12
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> !fifo_empty);
  // R6
  wfull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WFULL && !fifo_full) |=> (st == S_WFULL));
  // R6
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> dir_q);
  // R3
  bad_launch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && reg_we && reg_addr == 3'd0 && reg_wdata[14] && !size_ok) |=> (st == S_IDLE));
  // R7
  timeout_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q[1]) |-> ($past(tmo_q) == 24'd0 && st == S_IDLE));
  // R10
  done_last_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q[0]) |-> (blk_q == 12'd0 && st == S_IDLE));
  // R4
  bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (bits_q <= {bsize_q, 3'b000}));
endmodule

// File: tb/sd_data_xfer_tb.sv
module sd_data_xfer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fifo_push = 0, fifo_pop = 0;
  logic [31:0] fifo_wdata = 0, fifo_rdata;
  logic        fifo_full, fifo_empty;
  logic        sd_tick = 0, crc_fail = 0;
  logic [7:0]  dat_in = 8'hFF, dat_out;
  logic        dat_oe, irq;

  int nchk = 0, nerr = 0, seed = 0;

  sd_data_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .sd_tick(sd_tick),
    .dat_in(dat_in), .crc_fail(crc_fail), .dat_out(dat_out), .dat_oe(dat_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic tick(input logic [7:0] d);
    @(negedge clk); dat_in = d; sd_tick = 1;
    @(negedge clk); sd_tick = 0; dat_in = 8'hFF;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); fifo_push = 1; fifo_wdata = d;
    @(negedge clk); fifo_push = 0;
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] exp);
    @(negedge clk); #1 chk(tag, fifo_rdata, exp); fifo_pop = 1;
    @(negedge clk); fifo_pop = 0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1F2E3D4C ^ (i * 32'h9E3779B1);
  endfunction

  function automatic int wbits(input int wc);
    return (wc == 0) ? 1 : (wc == 1) ? 4 : 8;
  endfunction

  function automatic logic [31:0] wfld(input int wc);
    return (wc == 1) ? 32'h0001_0000 : (wc == 2) ? 32'h0400_0000 :
           (wc == 3) ? 32'h0401_0000 : 32'h0;
  endfunction

  task automatic do_read(input int wc, input int bsize, input int bnum,
                         input int timer, input int idle, input bit bad);
    logic [31:0] v, word;
    logic [7:0]  mask, lanes;
    int w = wbits(wc), widx = 0, base;
    base = seed; seed += 64;
    mask = 8'((1 << w) - 1);
    wr(1, bsize); wr(2, timer);
    wr(0, bnum | 32'h4000 | wfld(wc));
    rd(3, v); chk("R2 counter at launch", v, (bsize << 12) | bnum);
    rd(4, v); chk("R10 read active", v[1:0], 2'b01);
    wr(1, bsize + 4); rd(1, v); chk("R3 size write ignored while active", v, bsize);
    for (int b = 0; b < bnum; b++) begin
      repeat (idle) tick(8'hFF);
      tick(8'h00);
      for (int k = 0; k < bsize / 4; k++) begin
        word = pat(base + widx); widx++;
        for (int j = 0; j < 32 / w; j++) begin
          lanes = 8'((word >> (32 - w * (j + 1))) & 32'(mask));
          tick(lanes | ~mask);
          if (b == 0 && k == 0 && j == 0) begin
            rd(3, v); chk("R4 byte field mid block", (v >> 12) & 32'hFFF, (bsize * 8 - w) / 8);
          end
        end
      end
      crc_fail = bad;
      repeat (17) tick(8'hFF);
      crc_fail = 0;
      if (bad) break;
      if (b < bnum - 1) begin
        rd(3, v); chk("R4 counter at block boundary", v, (bsize << 12) | (bnum - 1 - b));
      end
    end
    rd(4, v);
    if (bad) begin
      chk("R8 read crc status", v, 32'h40);
      rd(6, v); chk("R8 read crc interrupt", v, 32'h4);
    end else begin
      chk("R10 done status", v, 32'h10);
      rd(6, v); chk("R10 done interrupt", v, 32'h1);
      chk("R11 irq follows cause", irq, 1'b1);
      rd(3, v); chk("R10 counter zero at end", v, 0);
    end
    for (int i = 0; i < widx; i++) pop_chk("R4 R5 read word", pat(base + i));
    chk("R12 fifo drained", fifo_empty, 1'b1);
    wr(6, 32'h3FF);
    @(negedge clk); chk("R11 irq cleared", irq, 1'b0);
  endtask

  task automatic do_write(input int wc, input int bsize, input int bnum, input bit bad);
    logic [31:0] v, word;
    logic [7:0]  mask, lanes;
    int w = wbits(wc), widx = 0, base, total;
    base = seed; seed += 64;
    total = bsize * bnum / 4;
    mask = 8'((1 << w) - 1);
    wr(1, bsize); wr(2, 100);
    wr(0, bnum | 32'h5000 | wfld(wc));
    for (int i = 0; i < total - 1; i++) push(pat(base + i));
    repeat (3) tick(8'hFF);
    chk("R6 no drive before full", dat_oe, 1'b0);
    rd(4, v); chk("R6 write waiting active", v[1:0], 2'b10);
    rd(5, v); chk("R12 fifo count", v, total - 1);
    push(pat(base + total - 1));
    rd(5, v); chk("R12 fifo full flag", v, 32'h800 | total);
    for (int b = 0; b < bnum; b++) begin
      tick(8'hFF);
      chk("R6 start bit", {dat_oe, dat_out}, 9'h100);
      for (int k = 0; k < bsize / 4; k++) begin
        word = pat(base + widx); widx++;
        for (int j = 0; j < 32 / w; j++) begin
          lanes = 8'((word >> (32 - w * (j + 1))) & 32'(mask));
          tick(8'hFF);
          chk("R5 R6 write lanes", {dat_oe, dat_out}, {1'b1, lanes | ~mask});
        end
      end
      crc_fail = bad;
      tick(8'hFF);
      chk("R6 release after data", dat_oe, 1'b0);
      repeat (16) tick(8'hFF);
      crc_fail = 0;
      if (bad) break;
      tick(8'hFE); tick(8'hFE);
      rd(6, v); chk("R9 busy holds", v[9], 1'b0);
      tick(8'hFF);
      rd(6, v); chk("R9 busy end interrupt", v[9], 1'b1);
      rd(4, v); chk("R9 busy done status", v[3], 1'b1);
      wr(6, 32'h200);
    end
    rd(4, v);
    if (bad) begin
      chk("R8 write crc status", v, 32'h80);
      rd(6, v); chk("R8 write crc interrupt", v, 32'h8);
      while (!fifo_empty) begin
        @(negedge clk); fifo_pop = 1; @(negedge clk); fifo_pop = 0;
      end
    end else begin
      chk("R10 write done status", v[4], 1'b1);
      rd(6, v); chk("R10 write done interrupt", v, 32'h1);
    end
    wr(6, 32'h3FF);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk("R1 register reset", v, 0);
    end
    chk("R1 outputs reset", {irq, dat_oe, dat_out, fifo_empty}, {2'b00, 8'hFF, 1'b1});

    wr(1, 6); wr(0, 32'h4001);
    tick(8'h00);
    rd(4, v); chk("R3 unaligned size ignored", v, 0);
    wr(1, 4); wr(0, 32'h4000);
    tick(8'h00);
    rd(4, v); chk("R3 zero count ignored", v, 0);
    wr(0, 32'h0401_9003);
    rd(0, v); chk("R2 control readback", v, 32'h0401_9003 & ~32'h4000);

    for (int wc = 0; wc < 4; wc++) begin
      do_read(wc, 4, 1, 20, 2, 0);
      do_read(wc, 8, 2, 20, 1, 0);
      do_read(wc, 32, 1, 20, 3, 0);
    end
    do_read(1, 8, 1, 5, 5, 0);
    do_read(2, 4, 2, 20, 0, 1);

    wr(1, 4); wr(2, 5); wr(0, 32'h4001);
    repeat (5) tick(8'hFF);
    rd(6, v); chk("R7 no timeout yet", v, 0);
    tick(8'hFF);
    rd(6, v); chk("R7 timeout interrupt", v, 32'h2);
    rd(4, v); chk("R7 timeout status", v, 32'h20);
    wr(6, 32'h1);
    rd(6, v); chk("R11 clear of unset bit", v, 32'h2);
    wr(6, 32'h2);
    @(negedge clk); chk("R11 irq after clear", irq, 1'b0);

    for (int wc = 0; wc < 4; wc++) begin
      do_write(wc, 16, 2, 0);
      do_write(wc, 32, 1, 0);
      do_write(wc, 8, 4, 0);
    end
    do_write(1, 16, 2, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule